// File: doc/BRIEF.md
# No-Wait Pipelined Synchronous SRAM

This block is a synthesizable model of a 32-bit word synchronous static RAM whose data bus can change direction on every cycle without idle turnaround slots. Every input is sampled on the rising clock edge. The sampled inputs are the address, three active-low chip selects, the read/write flag, the load/advance flag, four active-low byte-lane write enables and the clock enable. Reads and writes use one fixed pipeline. A command is sampled on an enabled edge. Its data moves on the bus two enabled edges later: read data leaves the block and write data enters it.

A two-bit burst sequencer extends a loaded command over further cycles. It steps through the four words of the aligned group, either in interleaved order or in linear wrap-around order. The burst keeps the read or write type it was loaded with. The model uses split data ports, `wr_data` and `rd_data`. The `bus_drive` flag marks the cycles in which a shared bidirectional bus would be driven by the RAM.

Top module: `nowait_sram`

## Requirements
- R1: A read sampled at enabled edge k drives `rd_data` with the word at its address, and raises `bus_drive`, right after enabled edge k+2. The value holds until the next enabled edge.
- R2: A write sampled at enabled edge k stores `wr_data` as it is sampled at enabled edge k+2. Lane enable `byte_we_n[i]` (active low) guards bits 8i+7:8i, so bit 0 covers 7:0 and bit 3 covers 31:24. Lanes whose enable is high keep their old contents.
- R3: Reads and writes may alternate on consecutive cycles with no idle cycle. A read issued on the cycle right after a write to the same address returns the newly written lanes merged with the old contents of the other lanes.
- R4: An edge at which `clk_en_n` is high is ignored. No register changes, so `rd_data` and `bus_drive` hold. Pipeline latency counts only enabled edges.
- R5: With `ld_adv` high, `rd_wr_n` and `addr` are ignored. The next word of the loaded burst is accessed with the type that was latched at load. The low two address bits follow base XOR n when `seq_linear`=0, and follow base+n modulo 4 when `seq_linear`=1. The upper bits stay at the base value.
- R6: A load cycle (`ld_adv`=0) with any `chip_sel_n` bit high is a deselect. It writes nothing, and `bus_drive` is low two enabled edges later.
- R7: `out_en_n` high forces `bus_drive` low at once, without waiting for a clock edge.
- R8: After reset, `bus_drive` is 0 and `rd_data` is 0. An advance cycle with no active burst (after reset or after a deselect) performs no access.
- R9: A write with all four lane enables high changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high ignores the edge |
| chip_sel_n | input | 3 | Active-low chip selects; all must be low to select |
| ld_adv | input | 1 | 0 loads a new command, 1 advances the burst |
| rd_wr_n | input | 1 | 1 read, 0 write (used on load only) |
| byte_we_n | input | 4 | Active-low byte-lane write enables |
| addr | input | AW | Word address |
| seq_linear | input | 1 | Burst order: 0 interleaved, 1 linear |
| out_en_n | input | 1 | Active-low output enable, asynchronous |
| wr_data | input | 32 | Write data, sampled two enabled edges after its command |
| rd_data | output | 32 | Registered read data |
| bus_drive | output | 1 | High when read data would be driven on a shared bus |

## Verification
The bench goes after a read placed directly behind a write to the same word, where only one lane is written. A design without forwarding would return the stale word from before the write. It sends a burst whose loaded address is not group-aligned, in both orders. A sequencer that mixed up the orders, or let `rd_wr_n` change the burst type, would touch the wrong words or write during a read burst. It stalls the pipeline while a read result is in flight. A design that kept counting latency during stalls would show data early or lose the held value. It also probes advance cycles after a deselect and writes with every lane disabled. Both must leave the memory untouched, which later reads confirm.

// File: rtl/nowait_sram_pkg.sv
package nowait_sram_pkg;
  localparam int LANE_W = 8;

  typedef enum logic {
    SEQ_INTERLEAVE = 1'b0,
    SEQ_LINEAR     = 1'b1
  } seq_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import nowait_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  input  logic          sel,
  input  logic          rd_wr_n,
  input  logic          seq_linear,
  input  logic [AW-1:0] addr_in,
  output logic          iss_valid,
  output logic          iss_wr,
  output logic [AW-1:0] iss_addr
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          active_q;
  logic          wr_q;
  logic [1:0]    step;
  logic [1:0]    nxt_lo;

  assign step   = cnt_q + 2'd1;
  assign nxt_lo = (seq_e'(seq_linear) == SEQ_LINEAR) ? (base_q[1:0] + step)
                                                     : (base_q[1:0] ^ step);

  always_comb begin
    if (load) begin
      iss_valid = sel;
      iss_wr    = ~rd_wr_n;
      iss_addr  = addr_in;
    end else begin
      iss_valid = active_q;
      iss_wr    = wr_q;
      iss_addr  = {base_q[AW-1:2], nxt_lo};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else if (en) begin
      if (load) begin
        active_q <= sel;
        base_q   <= addr_in;
        cnt_q    <= '0;
        wr_q     <= ~rd_wr_n;
      end else if (active_q) begin
        cnt_q <= step;
      end
    end
  end

  // R5: burst type cannot change while advancing
  p_type_held_r5: assert property (@(posedge clk) disable iff (rst)
    (!load || !en) |=> $stable(wr_q));
  // R8: an advance with no live burst issues nothing
  p_idle_adv_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !active_q) |-> !iss_valid);
endmodule

// File: rtl/sram_bytes.sv
module sram_bytes
  import nowait_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic                   clk,
  input  logic                   en,
  input  logic                   we,
  input  logic [NB-1:0]          be,
  input  logic [AW-1:0]          waddr,
  input  logic [NB*LANE_W-1:0]   wdata,
  input  logic                   re,
  input  logic [AW-1:0]          raddr,
  output logic [NB*LANE_W-1:0]   rdata_q
);
  localparam int DEPTH = 1 << AW;

  logic [NB-1:0][LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int b = 0; b < NB; b++) begin
        if (be[b]) mem[waddr][b] <= wdata[b*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && re) rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
  import nowait_sram_pkg::*;
#(
  parameter  int AW = 8,
  parameter  int NB = 4,
  localparam int DW = NB * LANE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_en_n,
  input  logic [2:0]    chip_sel_n,
  input  logic          ld_adv,
  input  logic          rd_wr_n,
  input  logic [NB-1:0] byte_we_n,
  input  logic [AW-1:0] addr,
  input  logic          seq_linear,
  input  logic          out_en_n,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          bus_drive
);
  logic          en;
  logic          iss_valid, iss_wr;
  logic [AW-1:0] iss_addr;

  logic          s1_valid, s1_wr, s2_valid, s2_wr;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [NB-1:0] s1_be, s2_be;

  logic          fwd_hit_q;
  logic [NB-1:0] fwd_be_q;
  logic [DW-1:0] fwd_data_q;
  logic [DW-1:0] arr_q;
  logic [DW-1:0] merged;
  logic [DW-1:0] rdata_q;
  logic          drv_q;

  assign en = ~clk_en_n;

  burst_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .load       (~ld_adv),
    .sel        (~|chip_sel_n),
    .rd_wr_n    (rd_wr_n),
    .seq_linear (seq_linear),
    .addr_in    (addr),
    .iss_valid  (iss_valid),
    .iss_wr     (iss_wr),
    .iss_addr   (iss_addr)
  );

  sram_bytes #(.AW(AW), .NB(NB)) u_mem (
    .clk     (clk),
    .en      (en),
    .we      (s2_valid && s2_wr),
    .be      (s2_be),
    .waddr   (s2_addr),
    .wdata   (wr_data),
    .re      (s1_valid && !s1_wr),
    .raddr   (s1_addr),
    .rdata_q (arr_q)
  );

  // command pipeline, frozen as a whole by the clock enable
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_be    <= '0;
      s2_valid <= 1'b0;
      s2_wr    <= 1'b0;
      s2_addr  <= '0;
      s2_be    <= '0;
    end else if (en) begin
      s1_valid <= iss_valid;
      s1_wr    <= iss_wr;
      s1_addr  <= iss_addr;
      s1_be    <= ~byte_we_n;
      s2_valid <= s1_valid;
      s2_wr    <= s1_wr;
      s2_addr  <= s1_addr;
      s2_be    <= s1_be;
    end
  end

  // capture a write that commits in the same edge the array is read
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit_q  <= 1'b0;
      fwd_be_q   <= '0;
      fwd_data_q <= '0;
    end else if (en) begin
      fwd_hit_q  <= s1_valid && !s1_wr && s2_valid && s2_wr && (s1_addr == s2_addr);
      fwd_be_q   <= s2_be;
      fwd_data_q <= wr_data;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged[b*LANE_W +: LANE_W] = (fwd_hit_q && fwd_be_q[b])
                                        ? fwd_data_q[b*LANE_W +: LANE_W]
                                        : arr_q[b*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      drv_q   <= 1'b0;
    end else if (en) begin
      drv_q <= s2_valid && !s2_wr;
      if (s2_valid && !s2_wr) rdata_q <= merged;
    end
  end

  assign rd_data   = rdata_q;
  assign bus_drive = drv_q && !out_en_n;

  // R4: a disabled edge leaves output and pipeline untouched
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(rdata_q) && $stable(drv_q) && $stable(s2_valid)));
  // R1: a read at the pipeline end drives on the next enabled edge
  p_read_drives_r1: assert property (@(posedge clk) disable iff (rst)
    (en && s2_valid && !s2_wr) |=> drv_q);
  // R6: no read at the pipeline end releases the bus
  p_idle_release_r6: assert property (@(posedge clk) disable iff (rst)
    (en && !(s2_valid && !s2_wr)) |=> !drv_q);
  // R3: forwarding is only armed for a read behind a write
  p_fwd_source_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !(s1_valid && !s1_wr)) |=> !fwd_hit_q);
endmodule

// File: tb/nowait_sram_bench.sv
module nowait_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NROWS = 19;

  logic        clk = 1'b0;
  logic        rst;
  logic        clk_en_n;
  logic [2:0]  chip_sel_n;
  logic        ld_adv;
  logic        rd_wr_n;
  logic [3:0]  byte_we_n;
  logic [AW-1:0] addr;
  logic        seq_linear;
  logic        out_en_n;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        bus_drive;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nowait_sram #(.AW(AW), .NB(4)) u_nowait_sram (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .chip_sel_n(chip_sel_n),
    .ld_adv(ld_adv), .rd_wr_n(rd_wr_n), .byte_we_n(byte_we_n), .addr(addr),
    .seq_linear(seq_linear), .out_en_n(out_en_n), .wr_data(wr_data),
    .rd_data(rd_data), .bus_drive(bus_drive)
  );

  // row: {clk_en_n, chip_sel_n, ld_adv, rd_wr_n, byte_we_n, addr, wr_data, chk, exp_drv, exp_rd}
  localparam logic [83:0] VEC [NROWS] = '{
    {1'b0,3'b000,1'b0,1'b0,4'b0000,8'h10,32'h0,       1'b1,1'b0,32'h0},
    {1'b0,3'b000,1'b0,1'b0,4'b0000,8'h11,32'h0,       1'b1,1'b0,32'h0},
    {1'b0,3'b000,1'b0,1'b1,4'b0000,8'h10,32'hAAAA0000,1'b1,1'b0,32'h0},
    {1'b0,3'b000,1'b0,1'b1,4'b0000,8'h11,32'hBBBB1111,1'b1,1'b0,32'h0},
    {1'b0,3'b000,1'b0,1'b0,4'b1110,8'h10,32'h0,       1'b1,1'b1,32'hAAAA0000},
    {1'b0,3'b000,1'b0,1'b1,4'b0000,8'h10,32'h0,       1'b1,1'b1,32'hBBBB1111},
    {1'b0,3'b001,1'b0,1'b1,4'b0000,8'h00,32'h123456C3,1'b1,1'b0,32'h0},
    {1'b0,3'b001,1'b0,1'b1,4'b0000,8'h00,32'h0,       1'b1,1'b1,32'hAAAA00C3},
    {1'b0,3'b000,1'b0,1'b0,4'b0000,8'h20,32'h0,       1'b1,1'b0,32'h0},
    {1'b0,3'b000,1'b1,1'b1,4'b0000,8'hFF,32'h0,       1'b1,1'b0,32'h0},
    {1'b0,3'b000,1'b1,1'b1,4'b0000,8'hFF,32'hD0D00000,1'b1,1'b0,32'h0},
    {1'b0,3'b000,1'b1,1'b1,4'b0000,8'hFF,32'h0000D1D1,1'b1,1'b0,32'h0},
    {1'b0,3'b000,1'b0,1'b1,4'b0000,8'h21,32'h22222222,1'b1,1'b0,32'h0},
    {1'b0,3'b000,1'b1,1'b0,4'b0000,8'hFF,32'h33333333,1'b1,1'b0,32'h0},
    {1'b0,3'b000,1'b1,1'b0,4'b0000,8'hFF,32'h0,       1'b1,1'b1,32'h0000D1D1},
    {1'b0,3'b000,1'b1,1'b0,4'b0000,8'hFF,32'h0,       1'b1,1'b1,32'hD0D00000},
    {1'b0,3'b100,1'b0,1'b1,4'b0000,8'h00,32'h0,       1'b1,1'b1,32'h33333333},
    {1'b0,3'b100,1'b0,1'b1,4'b0000,8'h00,32'h0,       1'b1,1'b1,32'h22222222},
    {1'b0,3'b100,1'b0,1'b1,4'b0000,8'h00,32'h0,       1'b1,1'b0,32'h0}
  };

  function automatic string row_req(int i);
    if (i < 4)  return "R1";
    if (i < 8)  return "R2/R3";
    if (i < 16) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, logic exp_drv, logic [31:0] exp_rd, bit cmp_rd);
    n_checks++;
    if (bus_drive !== exp_drv || (cmp_rd && rd_data !== exp_rd)) begin
      n_fail++;
      $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
               req, bus_drive, rd_data, exp_drv, exp_rd);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(logic cen, logic [2:0] cs, logic adv, logic rw,
                      logic [3:0] bw, logic [AW-1:0] a, logic [31:0] wd);
    clk_en_n = cen; chip_sel_n = cs; ld_adv = adv; rd_wr_n = rw;
    byte_we_n = bw; addr = a; wr_data = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic desel(logic [31:0] wd);
    step(1'b0, 3'b010, 1'b0, 1'b1, 4'b0000, '0, wd);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: drive=%b data=%h expected drive=x data=x", bus_drive, rd_data);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; clk_en_n = 1'b0; chip_sel_n = 3'b111; ld_adv = 1'b0; rd_wr_n = 1'b1;
    byte_we_n = 4'hF; addr = '0; seq_linear = 1'b0; out_en_n = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R8 reset", 1'b0, 32'h0, 1'b1);

    for (int i = 0; i < NROWS; i++) begin
      logic [83:0] v;
      v = VEC[i];
      step(v[83], v[82:80], v[79], v[78], v[77:74], v[73:66], v[65:34]);
      if (v[33]) check(row_req(i), v[32], v[31:0], v[32]);
    end

    // R4 stall while a read of 0x10 is in flight
    step(1'b0, 3'b000, 1'b0, 1'b1, 4'b0000, 8'h10, '0);
    check("R4 before stall", 1'b0, '0, 1'b0);
    step(1'b1, 3'b000, 1'b0, 1'b0, 4'b0000, 8'h33, '0);
    check("R4 stall 1", 1'b0, '0, 1'b0);
    step(1'b1, 3'b000, 1'b0, 1'b0, 4'b0000, 8'h33, '0);
    check("R4 stall 2", 1'b0, '0, 1'b0);
    desel('0);
    check("R4 one enabled edge", 1'b0, '0, 1'b0);
    desel('0);
    check("R1 R4 data after two enabled edges", 1'b1, 32'hAAAA00C3, 1'b1);
    step(1'b1, 3'b000, 1'b0, 1'b0, 4'b0000, 8'h10, 32'hFFFFFFFF);
    check("R4 output held", 1'b1, 32'hAAAA00C3, 1'b1);
    out_en_n = 1'b1; #1;
    check("R7 output enable off", 1'b0, '0, 1'b0);
    out_en_n = 1'b0; #1;
    check("R7 output enable on", 1'b1, 32'hAAAA00C3, 1'b1);
    desel('0);
    check("R6 release after deselect", 1'b0, '0, 1'b0);

    // R5 linear order from 0x21: 21,22,23,20
    seq_linear = 1'b1;
    step(1'b0, 3'b000, 1'b0, 1'b1, 4'b0000, 8'h21, '0);
    step(1'b0, 3'b000, 1'b1, 1'b0, 4'b0000, 8'h00, '0);
    step(1'b0, 3'b000, 1'b1, 1'b0, 4'b0000, 8'h00, '0);
    check("R5 linear word 0", 1'b1, 32'h0000D1D1, 1'b1);
    step(1'b0, 3'b000, 1'b1, 1'b0, 4'b0000, 8'h00, '0);
    check("R5 linear word 1", 1'b1, 32'h22222222, 1'b1);
    desel('0);
    check("R5 linear word 2", 1'b1, 32'h33333333, 1'b1);
    desel('0);
    check("R5 linear word 3", 1'b1, 32'hD0D00000, 1'b1);
    seq_linear = 1'b0;

    // R8 advance with no live burst does nothing
    step(1'b0, 3'b000, 1'b1, 1'b0, 4'b0000, 8'h20, 32'hFFFFFFFF);
    step(1'b0, 3'b000, 1'b1, 1'b0, 4'b0000, 8'h20, 32'hFFFFFFFF);
    step(1'b0, 3'b000, 1'b1, 1'b0, 4'b0000, 8'h20, 32'hFFFFFFFF);
    check("R8 idle advance no drive", 1'b0, '0, 1'b0);
    step(1'b0, 3'b000, 1'b0, 1'b1, 4'b0000, 8'h20, 32'hFFFFFFFF);
    desel(32'hFFFFFFFF);
    desel(32'hFFFFFFFF);
    check("R8 idle advance wrote nothing", 1'b1, 32'hD0D00000, 1'b1);

    // R9 lane-less write and R6 deselected write leave 0x10 intact
    step(1'b0, 3'b000, 1'b0, 1'b0, 4'b1111, 8'h10, '0);
    step(1'b0, 3'b010, 1'b0, 1'b0, 4'b0000, 8'h10, '0);
    desel(32'hFFFFFFFF);
    desel(32'h00000000);
    step(1'b0, 3'b000, 1'b0, 1'b1, 4'b0000, 8'h10, '0);
    desel('0);
    desel('0);
    check("R9 R6 word unchanged", 1'b1, 32'hAAAA00C3, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule